// File: doc/BRIEF.md
# FP operate instruction decoder

This block classifies one 32-bit floating-point operate instruction for each accepted transfer. It matches the instruction against the two operate formats: a general group and a compare group. It decodes the 9-bit operation field into an operation class. For each of the two sources and the destination it reports a precision and whether the value has to be unpacked before use. It passes the three register numbers through and checks each register number against the alignment its precision needs. A compare must also have a zero destination field, because its result goes to the condition code.

The block also produces the updated status word that the decode implies. For any recognised instruction the three trap-type bits are cleared. If a register check fails, they are then loaded with the invalid-register code. An instruction that is not recognised leaves the status word exactly as it arrived.

Input and output are valid/ready streams. A transfer is accepted when `in_valid` and `in_ready` are both high at a rising clock edge. The decoded result is then held in an output register and offered with `out_valid` from the next cycle on. It stays there, unchanged, until it is taken with `out_ready`. `in_ready` is high whenever the output register is empty or is being emptied in the same cycle. A stalled consumer therefore stalls the producer, and no instruction is dropped.

Top module: `fpop_decoder`

## Requirements
- R1: An instruction belongs to the general group when (insn & 32'hC1F80000) == 32'h81A00000 and to the compare group when (insn & 32'hC1F80000) == 32'h81A80000. Any other instruction is unrecognised.
- R2: The operation field is insn[13:5]. `rs1_idx` is insn[18:14], `rs2_idx` is insn[4:0] and `rd_idx` is insn[29:25]. The three indices are passed through for every instruction.
- R3: `op_class` is coded 0 none, 1 add, 2 sub, 3 mul, 4 div, 5 sqrt, 6 move, 7 abs, 8 negate, 9 float-to-int, 10 int-to-float, 11 float-to-float, 12 compare, 13 signalling compare.
  - General group: add 0x041/0x042/0x043, sub 0x045/0x046/0x047, mul 0x049/0x04A/0x04B, div 0x04D/0x04E/0x04F (single/double/quad), sqrt 0x029/0x02A/0x02B, widening mul 0x069 and 0x06E, move 0x001, negate 0x005, abs 0x009, int-to-float 0x0C4/0x0C8/0x0CC, float-to-int 0x0D1/0x0D2/0x0D3, conversions 0x0C6/0x0C7/0x0C9/0x0CB/0x0CD/0x0CE.
  - Compare group: 0x051/0x052/0x053 compare and 0x055/0x056/0x057 signalling compare. An opcode is recognised only in its own group.
- R4: Precision codes are 0 none, 1 single, 2 double, 3 quad.
  - add/sub/mul/div use the precision of opcode bits [1:0] for all three operands.
  - sqrt has no rs1 and uses opcode bits [1:0] for rs2 and rd. Compares use bits [1:0] for rs1 and rs2 and give rd precision 0.
  - 0x069 reads singles and writes a double. 0x06E reads doubles and writes a quad.
  - Move/abs/negate and the integer conversions have no rs1 and treat the integer side as single. 0x0C4/0x0C8/0x0CC write single/double/quad, and 0x0D1/0x0D2/0x0D3 read single/double/quad.
  - The float-to-float conversions are, as rs2 to rd: 0x0C6 double to single, 0x0C7 quad to single, 0x0C9 single to double, 0x0CB quad to double, 0x0CD single to quad, 0x0CE double to quad.
- R5: An unpack flag is 1 for every present floating-point operand. It is 0 for an absent operand, for the integer source of int-to-float, for the integer result of float-to-int, and for both operands of move, abs and negate.
- R6: For a recognised instruction, `reg_err` is raised when any double operand has index bit 0 set or any quad operand has index bits 1:0 nonzero. Single operands and absent sources are not checked.
- R7: For a compare, `reg_err` is raised when `rd_idx` is nonzero.
- R8: For a recognised instruction, `fsr_out` equals `fsr_in` with bits 16:14 replaced by 6 when `reg_err` is set and by 0 otherwise. All other bits are unchanged.
- R9: An unrecognised instruction gives `unknown`=1, `op_class`=0, all precisions 0, all unpack flags 0, `reg_err`=0 and `fsr_out` equal to `fsr_in`.
- R10: `in_ready` = !`out_valid` || `out_ready`. A transfer accepted at an edge gives `out_valid`=1 after that edge. When `out_valid`=1 and `out_ready`=0 at an edge, `out_valid` and every result output keep their values. `out_valid` falls after an edge with `out_ready`=1 and no new transfer.
- R11: After reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Block can take an instruction |
| insn | input | 32 | Instruction word |
| fsr_in | input | FSR_W | Status word before this instruction |
| out_valid | output | 1 | Decoded result offered |
| out_ready | input | 1 | Consumer takes the result |
| op_class | output | 4 | Operation class (R3 coding) |
| unknown | output | 1 | Instruction not recognised |
| reg_err | output | 1 | Register alignment or compare-destination violation |
| rs1_prec | output | 2 | rs1 precision (R4 coding) |
| rs2_prec | output | 2 | rs2 precision |
| rd_prec | output | 2 | rd precision |
| rs1_unpack | output | 1 | rs1 needs unpacking |
| rs2_unpack | output | 1 | rs2 needs unpacking |
| rd_unpack | output | 1 | rd result needs packing |
| rs1_idx | output | 5 | rs1 register number |
| rs2_idx | output | 5 | rs2 register number |
| rd_idx | output | 5 | rd register number |
| fsr_out | output | FSR_W | Status word with trap-type update |

## Verification
A wrong entry in the opcode table shows up in `op_class`, a precision or an unpack flag on the very transfer that carries that opcode. The full sweep of all 512 operation-field values in both groups therefore exposes it in the first beat that uses it. A broken alignment check or trap-type merge is visible in `reg_err` and `fsr_out[16:14]` on the same beat. Sweeping every register number through each field separates the single, double, quad and compare-destination rules. A fault in the output register or the ready logic shows as a changed result, or a lost or duplicated beat, within one cycle of a stalled `out_ready`.

// File: rtl/fpdec_pkg.sv
package fpdec_pkg;

  localparam int IDX_W   = 5;
  localparam int OPF_W   = 9;
  localparam int OPF_LSB = 5;
  localparam int RS1_LSB = 14;
  localparam int RS2_LSB = 0;
  localparam int RD_LSB  = 25;

  localparam logic [31:0] FMT_MASK = 32'hC1F8_0000;
  localparam logic [31:0] FMT_GEN  = 32'h81A0_0000;
  localparam logic [31:0] FMT_CMP  = 32'h81A8_0000;

  localparam int NOPND    = 3;
  localparam int OPND_RS1 = 0;
  localparam int OPND_RS2 = 1;
  localparam int OPND_RD  = 2;

  typedef enum logic [1:0] {
    PREC_NONE = 2'd0,
    PREC_S    = 2'd1,
    PREC_D    = 2'd2,
    PREC_Q    = 2'd3
  } prec_e;

  typedef enum logic [3:0] {
    CLS_NONE = 4'd0,
    CLS_ADD  = 4'd1,
    CLS_SUB  = 4'd2,
    CLS_MUL  = 4'd3,
    CLS_DIV  = 4'd4,
    CLS_SQRT = 4'd5,
    CLS_MOV  = 4'd6,
    CLS_ABS  = 4'd7,
    CLS_NEG  = 4'd8,
    CLS_F2I  = 4'd9,
    CLS_I2F  = 4'd10,
    CLS_CVT  = 4'd11,
    CLS_CMP  = 4'd12,
    CLS_CMPE = 4'd13
  } op_class_e;

  typedef struct packed {
    logic                   known;
    op_class_e              cls;
    logic [NOPND-1:0][1:0]  prec;
    logic [NOPND-1:0]       unpack;
  } opinfo_t;

  // Build a table entry: class, then (precision, unpack) for rs1, rs2, rd.
  function automatic opinfo_t mk(op_class_e c,
                                 prec_e p1, logic u1,
                                 prec_e p2, logic u2,
                                 prec_e pd, logic ud);
    opinfo_t r;
    r.known          = 1'b1;
    r.cls            = c;
    r.prec[OPND_RS1] = p1;
    r.prec[OPND_RS2] = p2;
    r.prec[OPND_RD]  = pd;
    r.unpack         = '0;
    r.unpack[OPND_RS1] = u1;
    r.unpack[OPND_RS2] = u2;
    r.unpack[OPND_RD]  = ud;
    return r;
  endfunction

endpackage

// File: rtl/fpdec_opf_table.sv
module fpdec_opf_table
  import fpdec_pkg::*;
(
  input  logic             is_gen,
  input  logic             is_cmp,
  input  logic [OPF_W-1:0] opf,
  output opinfo_t          info
);

  always_comb begin
    info = '0;
    if (is_gen) begin
      case (opf)
        9'h041: info = mk(CLS_ADD,  PREC_S, 1'b1, PREC_S, 1'b1, PREC_S, 1'b1);
        9'h042: info = mk(CLS_ADD,  PREC_D, 1'b1, PREC_D, 1'b1, PREC_D, 1'b1);
        9'h043: info = mk(CLS_ADD,  PREC_Q, 1'b1, PREC_Q, 1'b1, PREC_Q, 1'b1);
        9'h045: info = mk(CLS_SUB,  PREC_S, 1'b1, PREC_S, 1'b1, PREC_S, 1'b1);
        9'h046: info = mk(CLS_SUB,  PREC_D, 1'b1, PREC_D, 1'b1, PREC_D, 1'b1);
        9'h047: info = mk(CLS_SUB,  PREC_Q, 1'b1, PREC_Q, 1'b1, PREC_Q, 1'b1);
        9'h049: info = mk(CLS_MUL,  PREC_S, 1'b1, PREC_S, 1'b1, PREC_S, 1'b1);
        9'h04A: info = mk(CLS_MUL,  PREC_D, 1'b1, PREC_D, 1'b1, PREC_D, 1'b1);
        9'h04B: info = mk(CLS_MUL,  PREC_Q, 1'b1, PREC_Q, 1'b1, PREC_Q, 1'b1);
        9'h04D: info = mk(CLS_DIV,  PREC_S, 1'b1, PREC_S, 1'b1, PREC_S, 1'b1);
        9'h04E: info = mk(CLS_DIV,  PREC_D, 1'b1, PREC_D, 1'b1, PREC_D, 1'b1);
        9'h04F: info = mk(CLS_DIV,  PREC_Q, 1'b1, PREC_Q, 1'b1, PREC_Q, 1'b1);
        9'h029: info = mk(CLS_SQRT, PREC_NONE, 1'b0, PREC_S, 1'b1, PREC_S, 1'b1);
        9'h02A: info = mk(CLS_SQRT, PREC_NONE, 1'b0, PREC_D, 1'b1, PREC_D, 1'b1);
        9'h02B: info = mk(CLS_SQRT, PREC_NONE, 1'b0, PREC_Q, 1'b1, PREC_Q, 1'b1);
        9'h069: info = mk(CLS_MUL,  PREC_S, 1'b1, PREC_S, 1'b1, PREC_D, 1'b1);
        9'h06E: info = mk(CLS_MUL,  PREC_D, 1'b1, PREC_D, 1'b1, PREC_Q, 1'b1);
        9'h001: info = mk(CLS_MOV,  PREC_NONE, 1'b0, PREC_S, 1'b0, PREC_S, 1'b0);
        9'h005: info = mk(CLS_NEG,  PREC_NONE, 1'b0, PREC_S, 1'b0, PREC_S, 1'b0);
        9'h009: info = mk(CLS_ABS,  PREC_NONE, 1'b0, PREC_S, 1'b0, PREC_S, 1'b0);
        9'h0C4: info = mk(CLS_I2F,  PREC_NONE, 1'b0, PREC_S, 1'b0, PREC_S, 1'b1);
        9'h0C8: info = mk(CLS_I2F,  PREC_NONE, 1'b0, PREC_S, 1'b0, PREC_D, 1'b1);
        9'h0CC: info = mk(CLS_I2F,  PREC_NONE, 1'b0, PREC_S, 1'b0, PREC_Q, 1'b1);
        9'h0D1: info = mk(CLS_F2I,  PREC_NONE, 1'b0, PREC_S, 1'b1, PREC_S, 1'b0);
        9'h0D2: info = mk(CLS_F2I,  PREC_NONE, 1'b0, PREC_D, 1'b1, PREC_S, 1'b0);
        9'h0D3: info = mk(CLS_F2I,  PREC_NONE, 1'b0, PREC_Q, 1'b1, PREC_S, 1'b0);
        9'h0C6: info = mk(CLS_CVT,  PREC_NONE, 1'b0, PREC_D, 1'b1, PREC_S, 1'b1);
        9'h0C7: info = mk(CLS_CVT,  PREC_NONE, 1'b0, PREC_Q, 1'b1, PREC_S, 1'b1);
        9'h0C9: info = mk(CLS_CVT,  PREC_NONE, 1'b0, PREC_S, 1'b1, PREC_D, 1'b1);
        9'h0CB: info = mk(CLS_CVT,  PREC_NONE, 1'b0, PREC_Q, 1'b1, PREC_D, 1'b1);
        9'h0CD: info = mk(CLS_CVT,  PREC_NONE, 1'b0, PREC_S, 1'b1, PREC_Q, 1'b1);
        9'h0CE: info = mk(CLS_CVT,  PREC_NONE, 1'b0, PREC_D, 1'b1, PREC_Q, 1'b1);
        default: info = '0;
      endcase
    end else if (is_cmp) begin
      case (opf)
        9'h051: info = mk(CLS_CMP,  PREC_S, 1'b1, PREC_S, 1'b1, PREC_NONE, 1'b0);
        9'h052: info = mk(CLS_CMP,  PREC_D, 1'b1, PREC_D, 1'b1, PREC_NONE, 1'b0);
        9'h053: info = mk(CLS_CMP,  PREC_Q, 1'b1, PREC_Q, 1'b1, PREC_NONE, 1'b0);
        9'h055: info = mk(CLS_CMPE, PREC_S, 1'b1, PREC_S, 1'b1, PREC_NONE, 1'b0);
        9'h056: info = mk(CLS_CMPE, PREC_D, 1'b1, PREC_D, 1'b1, PREC_NONE, 1'b0);
        9'h057: info = mk(CLS_CMPE, PREC_Q, 1'b1, PREC_Q, 1'b1, PREC_NONE, 1'b0);
        default: info = '0;
      endcase
    end
  end

  // A recognised entry always carries a real class; a compare never names a register destination.
  always_comb begin
    if (info.known) assert_known_class_R3: assert (info.cls != CLS_NONE);
    if (is_cmp && info.known) assert_cmp_no_rd_R7: assert (info.prec[OPND_RD] == PREC_NONE);
    if (!info.known) assert_unknown_blank_R9: assert (info.prec == '0 && info.unpack == '0);
  end

endmodule

// File: rtl/fpdec_align_chk.sv
module fpdec_align_chk
  import fpdec_pkg::*;
#(
  parameter int IDX_W_P = 5,
  parameter bit IS_DEST = 1'b0
) (
  input  logic [1:0]         prec,
  input  logic [IDX_W_P-1:0] idx,
  output logic               err
);

  always_comb begin
    case (prec_e'(prec))
      PREC_NONE: err = IS_DEST ? (idx != '0) : 1'b0;
      PREC_S:    err = 1'b0;
      PREC_D:    err = idx[0];
      PREC_Q:    err = (idx[1:0] != 2'b00);
      default:   err = 1'b0;
    endcase
  end

endmodule

// File: rtl/fpop_decoder.sv
module fpop_decoder
  import fpdec_pkg::*;
#(
  parameter int FSR_W      = 32,
  parameter int TT_LSB     = 14,
  parameter int TT_W       = 3,
  parameter int TT_REG_ERR = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [31:0]      insn,
  input  logic [FSR_W-1:0] fsr_in,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [3:0]       op_class,
  output logic             unknown,
  output logic             reg_err,
  output logic [1:0]       rs1_prec,
  output logic [1:0]       rs2_prec,
  output logic [1:0]       rd_prec,
  output logic             rs1_unpack,
  output logic             rs2_unpack,
  output logic             rd_unpack,
  output logic [IDX_W-1:0] rs1_idx,
  output logic [IDX_W-1:0] rs2_idx,
  output logic [IDX_W-1:0] rd_idx,
  output logic [FSR_W-1:0] fsr_out
);

  localparam int TT_MSB = TT_LSB + TT_W - 1;
  localparam logic [TT_W-1:0] TT_CODE = TT_W'(TT_REG_ERR);

  typedef struct packed {
    logic [3:0]                  cls;
    logic                        unk;
    logic                        err;
    logic [NOPND-1:0][1:0]       prec;
    logic [NOPND-1:0]            unpack;
    logic [NOPND-1:0][IDX_W-1:0] idx;
    logic [FSR_W-1:0]            fsr;
  } result_t;

  // Format match and field extraction.
  logic                        is_gen, is_cmp;
  logic [OPF_W-1:0]            opf;
  logic [NOPND-1:0][IDX_W-1:0] idx_v;

  assign is_gen = ((insn & FMT_MASK) == FMT_GEN);
  assign is_cmp = ((insn & FMT_MASK) == FMT_CMP);
  assign opf    = insn[OPF_LSB +: OPF_W];
  assign idx_v[OPND_RS1] = insn[RS1_LSB +: IDX_W];
  assign idx_v[OPND_RS2] = insn[RS2_LSB +: IDX_W];
  assign idx_v[OPND_RD]  = insn[RD_LSB  +: IDX_W];

  opinfo_t info;

  fpdec_opf_table u_table (
    .is_gen (is_gen),
    .is_cmp (is_cmp),
    .opf    (opf),
    .info   (info)
  );

  // One alignment checker per operand slot; the destination slot also enforces a zero field when it is absent.
  logic [NOPND-1:0] err_v;

  for (genvar g = 0; g < NOPND; g++) begin : g_opnd
    fpdec_align_chk #(
      .IDX_W_P (IDX_W),
      .IS_DEST (g == OPND_RD)
    ) u_chk (
      .prec (info.prec[g]),
      .idx  (idx_v[g]),
      .err  (err_v[g])
    );
  end

  logic             viol;
  logic [FSR_W-1:0] fsr_d;

  assign viol = info.known & (|err_v);

  always_comb begin
    fsr_d = fsr_in;
    if (info.known) fsr_d[TT_MSB:TT_LSB] = viol ? TT_CODE : '0;
  end

  result_t res_d, res_q;

  always_comb begin
    res_d.cls    = info.cls;
    res_d.unk    = ~info.known;
    res_d.err    = viol;
    res_d.prec   = info.prec;
    res_d.unpack = info.unpack;
    res_d.idx    = idx_v;
    res_d.fsr    = fsr_d;
  end

  // Output stage: single register slot with back-pressure.
  logic vld_q, load;

  assign in_ready = ~vld_q | out_ready;
  assign load     = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      if (load) begin
        vld_q <= 1'b1;
        res_q <= res_d;
      end else if (out_ready) begin
        vld_q <= 1'b0;
      end
    end
  end

  assign out_valid  = vld_q;
  assign op_class   = res_q.cls;
  assign unknown    = res_q.unk;
  assign reg_err    = res_q.err;
  assign rs1_prec   = res_q.prec[OPND_RS1];
  assign rs2_prec   = res_q.prec[OPND_RS2];
  assign rd_prec    = res_q.prec[OPND_RD];
  assign rs1_unpack = res_q.unpack[OPND_RS1];
  assign rs2_unpack = res_q.unpack[OPND_RS2];
  assign rd_unpack  = res_q.unpack[OPND_RD];
  assign rs1_idx    = res_q.idx[OPND_RS1];
  assign rs2_idx    = res_q.idx[OPND_RS2];
  assign rd_idx     = res_q.idx[OPND_RD];
  assign fsr_out    = res_q.fsr;

  // Stalled result must not move.
  assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(res_q)));

  // Accepted transfer appears on the next cycle.
  assert_accept_shows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // Unrecognised result is blank.
  assert_unknown_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && unknown) |-> (op_class == 4'd0 && !reg_err &&
                                rs1_prec == 2'd0 && rs2_prec == 2'd0 && rd_prec == 2'd0));

  // Trap-type field of a recognised result follows the violation flag.
  assert_trap_field_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !unknown) |-> (fsr_out[TT_MSB:TT_LSB] == (reg_err ? TT_CODE : '0)));

endmodule

// File: tb/test_fpop_decoder.sv
`timescale 1ns/1ps
module test_fpop_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] insn = '0;
  logic [31:0] fsr_in = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [3:0]  op_class;
  logic        unknown, reg_err;
  logic [1:0]  rs1_prec, rs2_prec, rd_prec;
  logic        rs1_unpack, rs2_unpack, rd_unpack;
  logic [4:0]  rs1_idx, rs2_idx, rd_idx;
  logic [31:0] fsr_out;

  always #10 clk = ~clk;

  fpop_decoder i_fpop_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .insn(insn), .fsr_in(fsr_in), .out_valid(out_valid), .out_ready(out_ready),
    .op_class(op_class), .unknown(unknown), .reg_err(reg_err),
    .rs1_prec(rs1_prec), .rs2_prec(rs2_prec), .rd_prec(rd_prec),
    .rs1_unpack(rs1_unpack), .rs2_unpack(rs2_unpack), .rd_unpack(rd_unpack),
    .rs1_idx(rs1_idx), .rs2_idx(rs2_idx), .rd_idx(rd_idx), .fsr_out(fsr_out)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  function automatic logic bad(input logic [1:0] p, input logic [4:0] x);
    return (p == 2'd2 && x[0]) || (p == 2'd3 && x[1:0] != 2'b00);
  endfunction

  // Expected bundle from the requirements.
  function automatic logic [61:0] model(input logic [31:0] i, input logic [31:0] f);
    logic g1, g2, known, err;
    logic [8:0] o;
    logic [3:0] c;
    logic [1:0] pa, pb, pd;
    logic ua, ub, ud;
    logic [31:0] fo;
    g1 = ((i & 32'hC1F80000) == 32'h81A00000);
    g2 = ((i & 32'hC1F80000) == 32'h81A80000);
    o = i[13:5];
    known = 1'b1; c = 4'd0; pa = 2'd0; pb = 2'd0; pd = 2'd0;
    ua = 1'b0; ub = 1'b0; ud = 1'b0;
    if (g1 && o[8:4] == 5'h04 && o[1:0] != 2'b00) begin
      c = 4'(o[3:2]) + 4'd1; pa = o[1:0]; pb = o[1:0]; pd = o[1:0];
      ua = 1'b1; ub = 1'b1; ud = 1'b1;
    end else if (g1 && o[8:2] == 7'h0A && o[1:0] != 2'b00) begin
      c = 4'd5; pb = o[1:0]; pd = o[1:0]; ub = 1'b1; ud = 1'b1;
    end else if (g2 && o[8:3] == 6'h0A && o[1:0] != 2'b00) begin
      c = o[2] ? 4'd13 : 4'd12; pa = o[1:0]; pb = o[1:0]; ua = 1'b1; ub = 1'b1;
    end else if (g1) begin
      case (o)
        9'h001: begin c = 4'd6; pb = 2'd1; pd = 2'd1; end
        9'h005: begin c = 4'd8; pb = 2'd1; pd = 2'd1; end
        9'h009: begin c = 4'd7; pb = 2'd1; pd = 2'd1; end
        9'h069: begin c = 4'd3; pa = 2'd1; pb = 2'd1; pd = 2'd2; ua = 1; ub = 1; ud = 1; end
        9'h06E: begin c = 4'd3; pa = 2'd2; pb = 2'd2; pd = 2'd3; ua = 1; ub = 1; ud = 1; end
        9'h0C4: begin c = 4'd10; pb = 2'd1; pd = 2'd1; ud = 1; end
        9'h0C8: begin c = 4'd10; pb = 2'd1; pd = 2'd2; ud = 1; end
        9'h0CC: begin c = 4'd10; pb = 2'd1; pd = 2'd3; ud = 1; end
        9'h0D1: begin c = 4'd9; pb = 2'd1; pd = 2'd1; ub = 1; end
        9'h0D2: begin c = 4'd9; pb = 2'd2; pd = 2'd1; ub = 1; end
        9'h0D3: begin c = 4'd9; pb = 2'd3; pd = 2'd1; ub = 1; end
        9'h0C6: begin c = 4'd11; pb = 2'd2; pd = 2'd1; ub = 1; ud = 1; end
        9'h0C7: begin c = 4'd11; pb = 2'd3; pd = 2'd1; ub = 1; ud = 1; end
        9'h0C9: begin c = 4'd11; pb = 2'd1; pd = 2'd2; ub = 1; ud = 1; end
        9'h0CB: begin c = 4'd11; pb = 2'd3; pd = 2'd2; ub = 1; ud = 1; end
        9'h0CD: begin c = 4'd11; pb = 2'd1; pd = 2'd3; ub = 1; ud = 1; end
        9'h0CE: begin c = 4'd11; pb = 2'd2; pd = 2'd3; ub = 1; ud = 1; end
        default: known = 1'b0;
      endcase
    end else begin
      known = 1'b0;
    end
    if (!known) begin
      c = 4'd0; pa = 2'd0; pb = 2'd0; pd = 2'd0; ua = 1'b0; ub = 1'b0; ud = 1'b0;
    end
    err = known && (bad(pa, i[18:14]) || bad(pb, i[4:0]) ||
                    ((pd == 2'd0) ? (i[29:25] != 5'd0) : bad(pd, i[29:25])));
    fo = f;
    if (known) fo[16:14] = err ? 3'd6 : 3'd0;
    return {c, !known, err, pa, pb, pd, ua, ub, ud, i[18:14], i[4:0], i[29:25], fo};
  endfunction

  function automatic logic [61:0] actual();
    return {op_class, unknown, reg_err, rs1_prec, rs2_prec, rd_prec,
            rs1_unpack, rs2_unpack, rd_unpack, rs1_idx, rs2_idx, rd_idx, fsr_out};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One transfer with the consumer always ready; result sampled at the following falling edge.
  task automatic xact(input logic [31:0] i, input logic [31:0] f, input string tag);
    logic [61:0] e;
    @(negedge clk);
    in_valid = 1'b1; insn = i; fsr_in = f;
    @(negedge clk);
    in_valid = 1'b0;
    e = model(i, f);
    check(out_valid === 1'b1 && actual() === e, tag, {1'b0, out_valid, actual()}, {2'b01, e});
  endtask

  initial begin
    logic [61:0] ea, eb;
    repeat (3) @(negedge clk);
    // R11: reset state
    check(out_valid === 1'b0 && in_ready === 1'b1, "R11 reset", {62'd0, out_valid, in_ready}, 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0, "R11 after release", {63'd0, out_valid}, 64'd0);

    // R3 R4 R5 R9: every operation field in both groups
    for (int o = 0; o < 512; o++)
      xact(32'h81A00000 | (32'(o) << 5), 32'h0001C000, "R3 R4 R5 R9 general group sweep");
    for (int o = 0; o < 512; o++)
      xact(32'h81A80000 | (32'(o) << 5), 32'hFFFFFFFF, "R3 R4 R5 R9 compare group sweep");

    // R1: format bits swept around one general and one compare opcode
    for (int k = 0; k < 256; k++) begin
      logic [7:0] kk;
      kk = 8'(k);
      xact({kk[1:0], 5'd0, kk[7:2], 5'd0, 9'h041, 5'd0}, 32'h12345678, "R1 format match add");
      xact({kk[1:0], 5'd0, kk[7:2], 5'd0, 9'h052, 5'd0}, 32'h8765C321, "R1 format match compare");
    end

    // R2 R6 R7 R8: each register field swept for several precision mixes
    begin
      logic [31:0] ops [8];
      ops[0] = 32'h81A00000 | (32'h043 << 5);
      ops[1] = 32'h81A00000 | (32'h042 << 5);
      ops[2] = 32'h81A00000 | (32'h041 << 5);
      ops[3] = 32'h81A00000 | (32'h06E << 5);
      ops[4] = 32'h81A00000 | (32'h0D3 << 5);
      ops[5] = 32'h81A00000 | (32'h02B << 5);
      ops[6] = 32'h81A80000 | (32'h053 << 5);
      ops[7] = 32'h81A80000 | (32'h051 << 5);
      for (int n = 0; n < 8; n++)
        for (int fld = 0; fld < 3; fld++)
          for (int r = 0; r < 32; r++) begin
            logic [31:0] w, f;
            w = ops[n];
            if (fld == 0) w[18:14] = 5'(r);
            else if (fld == 1) w[4:0] = 5'(r);
            else w[29:25] = 5'(r);
            f = 32'h5A5A5A5A ^ (32'(r) << 12) ^ (32'(fld) << 15);
            xact(w, f, "R2 R6 R7 R8 register field sweep");
          end
    end

    // R10: output pulses for one cycle when the consumer is ready
    xact(32'h81A00000 | (32'h049 << 5), 32'h0, "R10 single beat");
    @(negedge clk);
    check(out_valid === 1'b0, "R10 pulse ends", {63'd0, out_valid}, 64'd0);

    // R10: back-pressure holds result and blocks input
    ea = model(32'h81A00000 | (32'h04B << 5) | 32'h1, 32'hFFFF0000);
    eb = model(32'h81A80000 | (32'h056 << 5) | (32'd3 << 25), 32'h00004000);
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; insn = 32'h81A00000 | (32'h04B << 5) | 32'h1; fsr_in = 32'hFFFF0000;
    @(negedge clk);
    insn = 32'h81A80000 | (32'h056 << 5) | (32'd3 << 25); fsr_in = 32'h00004000;
    for (int s = 0; s < 3; s++) begin
      @(negedge clk);
      check(out_valid === 1'b1 && in_ready === 1'b0 && actual() === ea, "R10 stall holds",
            {out_valid, in_ready, actual()}, {2'b10, ea});
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1 && actual() === eb, "R10 next after stall",
          {1'b0, out_valid, actual()}, {2'b01, eb});
    @(negedge clk);
    check(out_valid === 1'b0 && in_ready === 1'b1, "R10 drained",
          {62'd0, out_valid, in_ready}, 64'd1);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule